// File: doc/BRIEF.md
# Masked Lane Pack and Unpack Unit

This block moves 32-bit elements between a 16-lane vector and a densely packed word array under a 16-bit lane mask. In pack mode the lanes whose mask bit is set are gathered into consecutive output slots, starting with the lowest enabled lane, and the number of words produced is reported. In unpack mode consecutive packed words are dealt out to the enabled lanes, and every other lane keeps the value supplied on a prior-value input. Unpack therefore undoes pack.

A third mode scans the mask for set bits in the forward direction. It returns the lowest set bit, or, in continuing form, the lowest set bit strictly above a given index. Software can walk every set bit of a mask this way without clearing any of them. When the mask-enable input is low, the mask is treated as all ones: pack and unpack become plain 16-word copies.

Each operation is launched with a one-cycle start pulse and completes on the next clock edge. A new operation may be launched on every cycle.

Top module: `vec_pack_unit`

## Requirements
- R1: Pack (op = 0) writes the element of the k-th enabled lane, counted from lane 0 upward, to output slot k.
- R2: On pack and unpack, count equals the number of set bits in the effective mask. Pack output slots at index count and above are zero.
- R3: Unpack (op = 1) gives enabled lane i the packed input word whose index is the number of enabled lanes below i. Each lane whose mask bit is 0 takes its word from prior_in.
- R4: With mask_en = 0 the effective mask is all ones: count is 16, and both pack and unpack copy data_in to data_out unchanged.
- R5: A scan (op[1] = 1) with scan_cont = 0 returns in scan_idx the lowest set bit of the effective mask and clears scan_none.
- R6: A scan with scan_cont = 1 considers only bit positions strictly greater than scan_from.
- R7: When a scan finds no qualifying bit, scan_none is 1 and scan_idx keeps its previous value. A scan leaves data_out unchanged.
- R8: done is high exactly in the cycle after a cycle with start high, so one operation per cycle is accepted. After reset done, data_out, count, scan_idx and scan_none are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation this cycle |
| op | input | 2 | 0 pack, 1 unpack, 2 or 3 scan |
| mask_en | input | 1 | 1 uses mask, 0 treats mask as all ones |
| mask | input | 16 | Lane mask, bit i for lane i |
| scan_cont | input | 1 | Continue scan above scan_from |
| scan_from | input | 4 | Bit index to resume after |
| data_in | input | 512 | Source vector or packed words, lane i at bits 32i+31:32i |
| prior_in | input | 512 | Previous destination lanes for unpack |
| done | output | 1 | Result valid |
| data_out | output | 512 | Packed or unpacked result |
| count | output | 5 | Words produced or consumed |
| scan_idx | output | 4 | Found bit index |
| scan_none | output | 1 | Scan found no bit |

## Verification
Some properties are checked by assertions on every cycle: the one-cycle done latency, the all-ones count and straight copy when the mask is off, zero pack slots beyond the count, unpack lanes keeping prior_in, a found index pointing at a set mask bit, and scan_idx holding on a miss. Other behaviour only shows up in the bench scenarios, which are compared against an independent model. These cover the exact lane order of packing and unpacking, the choice of the lowest qualifying bit, the continuing scan at its boundary indices, and data_out holding across scans between back-to-back operations.

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
  parameter int LANES = 16,
  parameter int W = 32,
  localparam int IW = $clog2(LANES),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic               mask_en,
  input  logic [LANES-1:0]   mask,
  input  logic               scan_cont,
  input  logic [IW-1:0]      scan_from,
  input  logic [LANES*W-1:0] data_in,
  input  logic [LANES*W-1:0] prior_in,
  output logic               done,
  output logic [LANES*W-1:0] data_out,
  output logic [CW-1:0]      count,
  output logic [IW-1:0]      scan_idx,
  output logic               scan_none
);

  logic [LANES-1:0]   eff;
  logic [CW-1:0]      pre [LANES];
  logic [CW-1:0]      total;
  logic [LANES*W-1:0] packed_v, unpacked_v;
  logic               hit;
  logic [IW-1:0]      hit_idx;

  assign eff   = mask_en ? mask : '1;
  assign total = pre[LANES-1] + CW'(eff[LANES-1]);

  always_comb begin
    pre[0] = '0;
    for (int i = 1; i < LANES; i++) pre[i] = pre[i-1] + CW'(eff[i-1]);
  end

  always_comb begin
    packed_v = '0;
    for (int i = 0; i < LANES; i++)
      if (eff[i]) packed_v[pre[i][IW-1:0]*W +: W] = data_in[i*W +: W];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++)
      unpacked_v[i*W +: W] = eff[i] ? data_in[pre[i][IW-1:0]*W +: W] : prior_in[i*W +: W];
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (eff[i] && (!scan_cont || i > int'(scan_from))) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      data_out  <= '0;
      count     <= '0;
      scan_idx  <= '0;
      scan_none <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        count <= total;
        case (op)
          2'd0: data_out <= packed_v;
          2'd1: data_out <= unpacked_v;
          default: begin
            if (hit) scan_idx <= hit_idx;
            scan_none <= !hit;
          end
        endcase
      end
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R8
  AST_NOMASK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mask_en && !op[1] |=> data_out == $past(data_in)); // R4
  AST_NOMASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !mask_en |=> count == CW'(LANES)); // R4
  AST_SCAN_HIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start && op[1] |=> scan_none || ((($past(eff) >> scan_idx) & LANES'(1)) != '0)); // R5
  AST_SCAN_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start && op[1] |=> !scan_none || $stable(scan_idx)); // R7
  AST_SCAN_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start && op[1] |=> $stable(data_out)); // R7

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    AST_UNPACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      start && op == 2'd1 && !eff[g] |=> data_out[g*W +: W] == $past(prior_in[g*W +: W])); // R3
    AST_PACK_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      start && op == 2'd0 && int'(total) <= g |=> data_out[g*W +: W] == '0); // R2
  end

endmodule

// File: tb/vec_pack_unit_tb.sv
module vec_pack_unit_tb;
  localparam int PERIOD = 10;
  localparam int L = 16;
  localparam int W = 32;

  typedef struct {
    logic [L*W-1:0] v;
    int cnt;
    int idx;
    bit none;
    string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, mask_en = 0, scan_cont = 0;
  logic [1:0] op = 0;
  logic [L-1:0] mask = 0;
  logic [3:0] scan_from = 0;
  logic [L*W-1:0] data_in = 0, prior_in = 0;
  logic done, scan_none;
  logic [L*W-1:0] data_out;
  logic [4:0] count;
  logic [3:0] scan_idx;

  int tests = 0, fails = 0;
  exp_t q[$];
  logic [L*W-1:0] m_vec = 0;
  int m_idx = 0;
  bit m_none = 0;

  always #(PERIOD/2) clk = ~clk;

  vec_pack_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask_en(mask_en),
    .mask(mask), .scan_cont(scan_cont), .scan_from(scan_from), .data_in(data_in),
    .prior_in(prior_in), .done(done), .data_out(data_out), .count(count),
    .scan_idx(scan_idx), .scan_none(scan_none));

  function automatic logic [L*W-1:0] pattern(int seed);
    logic [L*W-1:0] r;
    for (int i = 0; i < L; i++) r[i*W +: W] = 32'h1000_0000 * (seed + 1) + 32'(i * 257 + 3);
    return r;
  endfunction

  task automatic issue(input logic [1:0] o, input bit men, input logic [L-1:0] m,
                       input bit cont, input int from, input logic [L*W-1:0] din,
                       input logic [L*W-1:0] pri, input string tag);
    exp_t e;
    logic [L-1:0] eff;
    int k;
    @(negedge clk);
    op = o; mask_en = men; mask = m; scan_cont = cont; scan_from = 4'(from);
    data_in = din; prior_in = pri; start = 1;
    eff = men ? m : '1;
    k = 0;
    for (int i = 0; i < L; i++) if (eff[i]) k++;
    e.cnt = k; e.tag = tag;
    if (o == 2'd0) begin
      m_vec = '0; k = 0;
      for (int i = 0; i < L; i++) if (eff[i]) begin m_vec[k*W +: W] = din[i*W +: W]; k++; end
    end else if (o == 2'd1) begin
      k = 0;
      for (int i = 0; i < L; i++)
        if (eff[i]) begin m_vec[i*W +: W] = din[k*W +: W]; k++; end
        else m_vec[i*W +: W] = pri[i*W +: W];
    end else begin
      m_none = 1;
      for (int i = 0; i < L; i++)
        if (m_none && eff[i] && (!cont || i > from)) begin m_none = 0; m_idx = i; end
    end
    e.v = m_vec; e.idx = m_idx; e.none = m_none;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); start = 0; end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R8 done without pending op: actual done=1 expected done=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (data_out !== e.v || count !== 5'(e.cnt) || scan_idx !== 4'(e.idx) || scan_none !== e.none) begin
          fails++;
          $display("FAIL %s: actual data=%h cnt=%0d idx=%0d none=%0d expected data=%h cnt=%0d idx=%0d none=%0d",
                   e.tag, data_out, count, scan_idx, scan_none, e.v, e.cnt, e.idx, e.none);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (done !== 0 || data_out !== '0 || count !== 0 || scan_idx !== 0 || scan_none !== 0) begin
      fails++;
      $display("FAIL R8 reset state: actual done=%0d cnt=%0d idx=%0d none=%0d expected all 0",
               done, count, scan_idx, scan_none);
    end
    issue(0, 1, 16'hA5A5, 0, 0, pattern(1), '0, "R1 pack A5A5");
    issue(0, 1, 16'h8001, 0, 0, pattern(2), '0, "R1 R2 pack ends");
    issue(0, 1, 16'h0000, 0, 0, pattern(3), '0, "R2 pack empty");
    issue(0, 1, 16'hFFFF, 0, 0, pattern(4), '0, "R2 pack full");
    issue(0, 0, 16'h0003, 0, 0, pattern(5), '0, "R4 pack no mask");
    issue(1, 1, 16'h0F0F, 0, 0, pattern(6), pattern(7), "R3 unpack 0F0F");
    issue(1, 1, 16'h0000, 0, 0, pattern(8), pattern(9), "R3 unpack none");
    issue(1, 1, 16'h8421, 0, 0, pattern(10), pattern(11), "R3 unpack sparse");
    issue(1, 0, 16'h0000, 0, 0, pattern(12), pattern(13), "R4 unpack no mask");
    issue(2, 1, 16'h0100, 0, 0, '0, '0, "R5 scan lowest");
    issue(2, 1, 16'h0910, 1, 8, '0, '0, "R6 scan above 8");
    issue(2, 1, 16'h0910, 1, 4, '0, '0, "R6 scan above 4");
    issue(2, 1, 16'hFFFF, 1, 15, '0, '0, "R7 scan above 15 none");
    issue(2, 1, 16'h0000, 0, 0, '0, '0, "R7 scan empty mask");
    issue(2, 0, 16'h0000, 1, 0, '0, '0, "R4 R6 scan no mask");
    issue(0, 1, 16'h00F0, 0, 0, pattern(14), '0, "R8 back to back");
    idle(1);
    issue(2, 1, 16'h8000, 1, 14, '0, '0, "R6 scan top bit");
    idle(4);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending results: actual %0d expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule